// File: doc/BRIEF.md
# Strap-Addressed I2C Register Target

This block is an I2C target that runs on a system clock. It oversamples the bus clock and data lines and drives the data line through an open-drain enable. Its register file holds an 8-bit wiper position for a 256-step control and one spare 8-bit register. The wiper is also presented continuously on a parallel output.

The 7-bit bus address is a fixed five-bit prefix followed by two low bits. A three-level board strap, encoded as a 2-bit code, selects those two low bits.

A write is one fixed frame: the address with a write flag, a register-select byte, one data byte, then STOP. A readback sets the register pointer with an address-and-select sequence. A repeated START follows, then the address with a read flag. The target then streams the selected register until the controller declines a byte.

Top module: `potreg_i2c_target`

## Requirements
- R1: The target answers to address bits 01010 followed by {A1,A0}, sent MSB first with the R/W flag as the eighth bit. The strap code sets {A1,A0}: 2'b00 (tied low) gives 00 (0x28), 2'b01 (open) gives 01 (0x29), 2'b10 (tied high) gives 11 (0x2B), and 2'b11 is treated as tied high. A matching address byte is acknowledged by pulling SDA low in the ninth clock.
- R2: After an address byte that does not match, the target never drives SDA and changes no register until the next START or STOP.
- R3: In a write (address, R/W=0), the target acknowledges the register-select byte (0 = wiper, 1 = spare) and the data byte. The selected register takes the data byte as soon as its eighth bit has been received.
- R4: A register-select byte of 2 or more is not acknowledged, and no register changes for the rest of that transfer.
- R5: Bytes sent after the first data byte of a write are not acknowledged and change no register.
- R6: After a register select and a repeated START with the address and R/W=1, the target returns the selected register MSB first. Each byte the controller acknowledges is followed by the same register again.
- R7: When the controller does not acknowledge a read byte, the target releases SDA and keeps it released until the next START.
- R8: The target begins pulling SDA low only while the synchronized SCL is low.
- R9: After reset the wiper holds 0x80, the spare register holds 0x00, and SDA is released.
- R10: The wiper output always shows register 0 and changes only when a write to register 0 completes.
- R11: A START seen at any point abandons the transfer in progress and begins a new address byte. A write cut short by a START leaves its register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 2 | Address strap code: 00 low, 01 open, 10 high, 11 treated as high |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| wiper_o | output | 8 | Current wiper position (register 0) |

## Verification
Two functions can act in the same system cycle: a START or STOP seen on the synchronized lines, and a pending byte-completion step of the transfer engine. The START or STOP must win. The bench provokes this by cutting a data byte short with a START after four bits. It then confirms at the ports that the wiper keeps its old value and that a fresh address byte is still acknowledged. A second overlap is a register write completing in the same cycle that the wiper output is sampled. This is judged by checking the wiper after every one of 256 write values in a full sweep.

// File: rtl/potreg_pkg.sv
package potreg_pkg;

    localparam int DATA_W = 8;
    localparam logic [4:0] ADDR_PREFIX = 5'b01010;

    typedef enum logic [1:0] {
        STRAP_LOW  = 2'b00,
        STRAP_OPEN = 2'b01,
        STRAP_HIGH = 2'b10,
        STRAP_RSVD = 2'b11
    } strap_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } tstate_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    // Low two address bits selected by the three-level strap.
    function automatic logic [6:0] target_addr(input logic [1:0] code);
        logic [1:0] low;
        case (strap_e'(code))
            STRAP_LOW:  low = 2'b00;
            STRAP_OPEN: low = 2'b01;
            default:    low = 2'b11;
        endcase
        return {ADDR_PREFIX, low};
    endfunction

    // Power-up value of each register: wiper at mid-scale, others cleared.
    function automatic logic [DATA_W-1:0] reg_reset(input int idx);
        return (idx == 0) ? 8'h80 : 8'h00;
    endfunction

endpackage

// File: rtl/potreg_line_sync.sv
module potreg_line_sync
    import potreg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_q;
    logic                   sda_q;
    logic                   scl_s;
    logic                   sda_s;

    assign scl_s = scl_pipe[SYNC_STAGES-1];
    assign sda_s = sda_pipe[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_q    <= scl_s;
            sda_q    <= sda_s;
        end
    end

    always_comb begin
        ev.scl      = scl_s;
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end

endmodule

// File: rtl/potreg_regfile.sv
module potreg_regfile
    import potreg_pkg::*;
#(
    parameter int NUM_REGS = 2,
    parameter int PTR_W    = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_ptr,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] wiper
);

    logic [DATA_W-1:0] regs [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[i] <= reg_reset(i);
            end else if (wr_en && (wr_ptr == PTR_W'(i))) begin
                regs[i] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int j = 0; j < NUM_REGS; j++) begin
            if (rd_ptr == PTR_W'(j)) rd_data = regs[j];
        end
    end

    assign wiper = regs[0];

endmodule

// File: rtl/potreg_fsm.sv
module potreg_fsm
    import potreg_pkg::*;
#(
    parameter int NUM_REGS = 2,
    parameter int PTR_W    = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [6:0]        own_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic [PTR_W-1:0]  ptr,
    output logic              sda_oe,
    output tstate_e           state
);

    localparam logic [3:0] BITS_PER_BYTE = 4'(DATA_W);

    logic [3:0]        bitcnt;
    logic [DATA_W-1:0] shreg;
    logic              rw;
    logic              m_ack;
    logic              byte_done;
    logic              take_bit;
    logic              rx_state;

    assign rx_state  = (state == ST_ADDR) || (state == ST_CMD) || (state == ST_WDATA);
    assign take_bit  = rx_state && ev.scl_rise && (bitcnt != BITS_PER_BYTE);
    assign byte_done = rx_state && ev.scl_fall && (bitcnt == BITS_PER_BYTE);

    // Write strobe fires in the cycle the data byte is complete.
    assign wr_en   = (state == ST_WDATA) && byte_done && !ev.start && !ev.stop;
    assign wr_data = shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            bitcnt <= '0;
            shreg  <= '0;
            rw     <= 1'b0;
            m_ack  <= 1'b0;
            ptr    <= '0;
            sda_oe <= 1'b0;
        end else if (ev.start) begin
            state  <= ST_ADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else if (ev.stop) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else begin
            if (take_bit) begin
                shreg  <= {shreg[DATA_W-2:0], ev.sda};
                bitcnt <= bitcnt + 4'd1;
            end
            unique case (state)
                ST_ADDR: if (byte_done) begin
                    if (shreg[7:1] == own_addr) begin
                        rw     <= shreg[0];
                        sda_oe <= 1'b1;
                        state  <= ST_ADDR_ACK;
                    end else begin
                        state <= ST_IGNORE;
                    end
                end
                ST_ADDR_ACK: if (ev.scl_fall) begin
                    bitcnt <= '0;
                    if (rw) begin
                        shreg  <= rd_data;
                        sda_oe <= ~rd_data[DATA_W-1];
                        state  <= ST_RDATA;
                    end else begin
                        sda_oe <= 1'b0;
                        state  <= ST_CMD;
                    end
                end
                ST_CMD: if (byte_done) begin
                    if (int'(shreg) < NUM_REGS) begin
                        ptr    <= shreg[PTR_W-1:0];
                        sda_oe <= 1'b1;
                        state  <= ST_CMD_ACK;
                    end else begin
                        state <= ST_IGNORE;
                    end
                end
                ST_CMD_ACK: if (ev.scl_fall) begin
                    sda_oe <= 1'b0;
                    bitcnt <= '0;
                    state  <= ST_WDATA;
                end
                ST_WDATA: if (byte_done) begin
                    sda_oe <= 1'b1;
                    state  <= ST_WDATA_ACK;
                end
                ST_WDATA_ACK: if (ev.scl_fall) begin
                    sda_oe <= 1'b0;
                    state  <= ST_IGNORE;
                end
                ST_RDATA: if (ev.scl_fall) begin
                    if (bitcnt == BITS_PER_BYTE - 4'd1) begin
                        sda_oe <= 1'b0;
                        state  <= ST_RACK;
                    end else begin
                        bitcnt <= bitcnt + 4'd1;
                        shreg  <= {shreg[DATA_W-2:0], 1'b0};
                        sda_oe <= ~shreg[DATA_W-2];
                    end
                end
                ST_RACK: begin
                    if (ev.scl_rise) m_ack <= ~ev.sda;
                    if (ev.scl_fall) begin
                        if (m_ack) begin
                            bitcnt <= '0;
                            shreg  <= rd_data;
                            sda_oe <= ~rd_data[DATA_W-1];
                            state  <= ST_RDATA;
                        end else begin
                            state <= ST_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/potreg_i2c_target.sv
module potreg_i2c_target
    import potreg_pkg::*;
#(
    parameter int NUM_REGS    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [1:0]        strap_i,
    output logic              sda_oe_o,
    output logic [DATA_W-1:0] wiper_o
);

    localparam int PTR_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    bus_ev_t           ev;
    tstate_e           state;
    logic              wr_en;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;
    logic [PTR_W-1:0]  ptr;
    logic [6:0]        own_addr;
    logic              scl_sync;
    logic              start_seen;

    assign own_addr   = target_addr(strap_i);
    assign scl_sync   = ev.scl;
    assign start_seen = ev.start;

    potreg_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    potreg_fsm #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .own_addr (own_addr),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .ptr      (ptr),
        .sda_oe   (sda_oe_o),
        .state    (state)
    );

    potreg_regfile #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_ptr  (ptr),
        .wr_data (wr_data),
        .rd_ptr  (ptr),
        .rd_data (rd_data),
        .wiper   (wiper_o)
    );

endmodule

// File: rtl/potreg_checker.sv
module potreg_checker
    import potreg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              scl_s,
    input logic              start_ev,
    input logic              sda_oe,
    input logic              wr_en,
    input logic [DATA_W-1:0] wiper,
    input tstate_e           state
);

    assert_oe_rises_scl_low_R8: assert property (@(posedge clk) disable iff (rst)
        (sda_oe && !$past(sda_oe)) |-> !$past(scl_s));

    assert_ignore_released_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IGNORE) |-> !sda_oe);

    assert_oe_only_driving_R7: assert property (@(posedge clk) disable iff (rst)
        sda_oe |-> (state == ST_ADDR_ACK || state == ST_CMD_ACK ||
                    state == ST_WDATA_ACK || state == ST_RDATA));

    assert_wiper_holds_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(wr_en) && !$past(rst)) |-> $stable(wiper));

    assert_start_restart_R11: assert property (@(posedge clk) disable iff (rst)
        start_ev |=> (state == ST_ADDR));

    assert_reset_wiper_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (wiper == 8'h80 && !sda_oe));

endmodule

bind potreg_i2c_target potreg_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_s    (scl_sync),
    .start_ev (start_seen),
    .sda_oe   (sda_oe_o),
    .wr_en    (wr_en),
    .wiper    (wiper_o),
    .state    (state)
);

// File: tb/potreg_i2c_target_test.sv
module potreg_i2c_target_test;

    localparam int HALF = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] strap = 2'b01;
    logic       sda_oe;
    logic [7:0] wiper;
    logic       sda_line;

    int n_chk = 0;
    int n_bad = 0;
    int oe_cnt = 0;
    int r8_viol = 0;
    bit done = 0;

    assign sda_line = sda_m & ~sda_oe;

    always #5 clk = ~clk;

    potreg_i2c_target uut (
        .clk      (clk),
        .rst      (rst),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .strap_i  (strap),
        .sda_oe_o (sda_oe),
        .wiper_o  (wiper)
    );

    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (sda_oe) oe_cnt++;
        if (sda_oe && !oe_prev && scl) r8_viol++;
        oe_prev = sda_oe;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_addr(input logic [1:0] s);
        case (s)
            2'b00:   return 'h28;
            2'b01:   return 'h29;
            default: return 'h2B;
        endcase
    endfunction

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; waitc(HALF);
        scl = 1'b1;   waitc(HALF);
        sda_m = 1'b0; waitc(HALF);
        scl = 1'b0;   waitc(HALF);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; waitc(HALF);
        scl = 1'b1;   waitc(HALF);
        sda_m = 1'b1; waitc(HALF);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; waitc(HALF);
        scl = 1'b1; waitc(HALF);
        scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        sda_m = 1'b1; waitc(HALF);
        scl = 1'b1; waitc(HALF / 2);
        ack = ~sda_line;
        waitc(HALF - HALF / 2);
        scl = 1'b0;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] v);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            waitc(HALF);
            scl = 1'b1; waitc(HALF / 2);
            v[i] = sda_line;
            waitc(HALF - HALF / 2);
            scl = 1'b0;
        end
        sda_m = ~give_ack; waitc(HALF);
        scl = 1'b1; waitc(HALF);
        scl = 1'b0;
    endtask

    task automatic wr_reg(input logic [7:0] a7, input logic [7:0] cmd,
                          input logic [7:0] d, output logic [2:0] acks);
        logic a0, a1, a2;
        i2c_start();
        send_byte({a7[6:0], 1'b0}, a0);
        send_byte(cmd, a1);
        send_byte(d, a2);
        i2c_stop();
        acks = {a0, a1, a2};
    endtask

    // Pointer write, repeated START, two bytes read (ack then nack).
    task automatic rd_reg(input logic [7:0] cmd, output logic [7:0] d0,
                          output logic [7:0] d1, output logic [2:0] acks,
                          output logic oe_after);
        logic a0, a1, a2;
        i2c_start();
        send_byte({exp_addr(strap)[6:0], 1'b0}, a0);
        send_byte(cmd, a1);
        i2c_start();
        send_byte({exp_addr(strap)[6:0], 1'b1}, a2);
        recv_byte(1'b1, d0);
        recv_byte(1'b0, d1);
        waitc(4 * HALF);
        oe_after = sda_oe;
        i2c_stop();
        acks = {a0, a1, a2};
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [2:0] acks;
        logic [7:0] d0, d1;
        logic       oe_after, ack;
        int         snap;
        logic [7:0] ref_wiper, ref_spare;

        waitc(5);
        rst = 1'b0;
        waitc(3);
        // R9: reset state
        chk("R9 wiper", wiper, 'h80);
        chk("R9 sda_oe", sda_oe, 0);
        rd_reg(8'd1, d0, d1, acks, oe_after);
        chk("R9 spare", d0, 'h00);
        ref_wiper = 8'h80;
        ref_spare = 8'h00;

        // R1/R2: every strap code against matching and foreign addresses
        for (int s = 0; s < 4; s++) begin
            strap = 2'(s);
            for (int k = 0; k < 6; k++) begin
                int a;
                a = (k < 4) ? ('h28 + k) : ((k == 4) ? 'h2C : 'h68);
                snap = oe_cnt;
                i2c_start();
                send_byte({7'(a), 1'b0}, ack);
                if (a == exp_addr(strap)) begin
                    i2c_stop();
                    chk("R1 address ack", ack, 1);
                end else begin
                    send_byte(8'h00, ack);
                    send_byte(8'h11, ack);
                    i2c_stop();
                    chk("R2 no drive", oe_cnt - snap, 0);
                    chk("R2 wiper kept", wiper, ref_wiper);
                end
            end
        end

        // R3/R10/R6: full wiper sweep with periodic readback
        strap = 2'b01;
        for (int v = 0; v < 256; v++) begin
            wr_reg(8'h29, 8'd0, 8'(v), acks);
            chk("R3 acks", acks, 3'b111);
            chk("R10 wiper", wiper, v);
            ref_wiper = 8'(v);
            if (v % 32 == 5) begin
                rd_reg(8'd0, d0, d1, acks, oe_after);
                chk("R6 acks", acks, 3'b111);
                chk("R6 first byte", d0, v);
                chk("R6 repeat byte", d1, v);
                chk("R7 released", oe_after, 0);
            end
        end

        // R3: spare register write and readback
        wr_reg(8'h29, 8'd1, 8'h5A, acks);
        chk("R3 spare acks", acks, 3'b111);
        ref_spare = 8'h5A;
        chk("R10 wiper untouched", wiper, ref_wiper);
        rd_reg(8'd1, d0, d1, acks, oe_after);
        chk("R3 spare read", d0, 'h5A);

        // R4: nonexistent register select
        for (int c = 2; c < 5; c++) begin
            wr_reg(8'h29, 8'(c), 8'hC3, acks);
            chk("R4 acks", acks, 3'b100);
            chk("R4 wiper", wiper, ref_wiper);
        end
        rd_reg(8'd1, d0, d1, acks, oe_after);
        chk("R4 spare", d0, ref_spare);

        // R5: extra byte after the data byte
        i2c_start();
        send_byte({7'h29, 1'b0}, ack);
        send_byte(8'd1, ack);
        send_byte(8'h77, ack);
        chk("R5 data ack", ack, 1);
        send_byte(8'h99, ack);
        chk("R5 extra nack", ack, 0);
        i2c_stop();
        ref_spare = 8'h77;
        rd_reg(8'd1, d0, d1, acks, oe_after);
        chk("R5 spare", d0, 'h77);

        // R11: START cuts a data byte short
        i2c_start();
        send_byte({7'h29, 1'b0}, ack);
        send_byte(8'd0, ack);
        for (int i = 0; i < 4; i++) send_bit(1'b0);
        i2c_start();
        send_byte({7'h29, 1'b0}, ack);
        chk("R11 new address ack", ack, 1);
        i2c_stop();
        chk("R11 wiper kept", wiper, ref_wiper);

        // R7: after a nack the line stays released through further clocks
        i2c_start();
        send_byte({7'h29, 1'b0}, ack);
        send_byte(8'd0, ack);
        i2c_start();
        send_byte({7'h29, 1'b1}, ack);
        recv_byte(1'b0, d0);
        snap = oe_cnt;
        for (int i = 0; i < 9; i++) send_bit(1'b1);
        chk("R7 no drive after nack", oe_cnt - snap, 0);
        chk("R6 single read", d0, ref_wiper);
        i2c_stop();

        chk("R8 drive starts while SCL low", r8_viol, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule